// File: doc/BRIEF.md
# HDLC Transmit Framer with Shared Flags

The framer turns frames presented as a byte stream into a serial HDLC line signal. Between frames it sends the flag octet 0x7E without a break. When a frame's first byte is on offer at the end of a flag, the framer takes it and shifts the byte out bit by bit. It inserts a zero after every run of five ones, and after the last byte it appends a frame check sequence followed by a closing flag. An external strobe `bit_en` paces every output bit, so the line rate is set outside the block. Each strobe produces exactly one line bit one clock later, marked by `tx_bit_valid`.

The check sequence is either 16-bit CRC-CCITT or 32-bit CRC, and its starting value is either all ones or all zeros. In shared-flag mode, when the next frame is already waiting, one flag both closes a frame and opens the next. Without it, each frame gets a closing flag and then its own opening flag. An active-low request-to-send output follows transmission, follows a receive-activity input, or stays idle, depending on a two-bit mode field.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `rts_n` is 1 and `tx_bit_valid` is 0. `tx_bit_valid` is 1 in exactly the clock cycle after each cycle with `bit_en` = 1. With no byte offered, the line carries back-to-back 0x7E flags, least significant bit first.
- R2: Bytes are sent least significant bit first. `in_ready` rises only in a cycle with `bit_en` = 1 in which the last bit of a flag or of the previous byte goes out. Two accepted bytes are therefore at least 8 strobes apart. A frame holds the accepted bytes up to and including the one marked `in_last`, and every frame is decoded with exactly its bytes and no extra ones.
- R3: A 0 is inserted after every five consecutive 1s in the payload and the check sequence, and never inside a flag. The line never carries seven 1s in a row.
- R4: With `crc32_sel` = 0, the check sequence is the 16-bit CRC with polynomial x^16+x^12+x^5+1, computed bit-reflected over the payload. It is sent complemented as 2 bytes, low-order byte first.
- R5: With `crc32_sel` = 1, the check sequence is the 32-bit Ethernet CRC (reflected polynomial 0xEDB88320) over the payload. It is sent complemented as 4 bytes, low-order byte first.
- R6: The CRC register starts each frame at all ones when `crc_preset_zero` = 0 and at all zeros when it is 1. The CRC width and the preset are taken when the frame's first byte is accepted.
- R7: With `share_flags` = 1 and the next frame's first byte offered when a closing flag ends, exactly one flag separates the two frames.
- R8: With `share_flags` = 0, exactly two flags separate back-to-back frames: a closing flag and then an opening flag.
- R9: With `rts_mode` = 00 or 01, `rts_n` is 0 in the clock cycles when a payload or check-sequence bit is marked by `tx_bit_valid`, and 1 when a flag bit is marked.
- R10: With `rts_mode` = 10, `rts_n` is 1 in every cycle.
- R11: With `rts_mode` = 11, `rts_n` in each cycle equals the inverse of `rx_frame_active` as sampled on the previous clock edge.
- R12: If `in_valid` is 0 at a byte boundary inside a frame whose last byte has not yet been marked, the frame ends there. Its check sequence and closing flag follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe; one line bit per strobe |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Byte to transmit |
| in_last | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Offered byte is taken in this cycle |
| crc32_sel | input | 1 | 0: 16-bit CRC, 1: 32-bit CRC |
| crc_preset_zero | input | 1 | 0: preset all ones, 1: preset all zeros |
| share_flags | input | 1 | 1: one flag may close a frame and open the next |
| rts_mode | input | 2 | 0X: follow transmission, 10: always high, 11: follow receiver |
| rx_frame_active | input | 1 | Receiver reports a frame in progress |
| tx_bit | output | 1 | Serial line bit |
| tx_bit_valid | output | 1 | `tx_bit` holds a new bit in this cycle |
| rts_n | output | 1 | Active-low request to send |

## Verification
A wrong sequencer state shows up on the line within one flag time. A flag comes out of phase, a byte is taken too early or too late, or the number of flags between frames is wrong, and a receiver-side decoder on the serial output sees each of these at the next flag. A wrong run counter in the stuffer shows up as an extra or missing zero, or as a run of seven ones. A slip in the CRC register has no effect until the end of the frame, and there the decoded check sequence is wrong. A wrong request-to-send state is seen in the same cycle as the line bit it goes with.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 6;
    localparam int CRC_W  = 32;
    localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;

    typedef enum logic [1:0] {
        ST_IDLE_FLAG,
        ST_DATA,
        ST_FCS,
        ST_CLOSE_FLAG
    } tx_state_e;

    typedef struct packed {
        tx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              last;
        logic              bit_o;
        logic              valid;
    } seq_t;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             wide;
    } crc_t;

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_NARROW = 32'h0000_8408,
    parameter logic [CRC_W-1:0] POLY_WIDE   = 32'hEDB8_8320,
    parameter int               NARROW_W    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic wide_sel,
    input  logic preset_zero,
    input  logic update,
    input  logic data_bit,
    input  logic shift,
    output logic fcs_bit,
    output logic wide
);

    localparam logic [CRC_W-1:0] ONES_WIDE   = '1;
    localparam logic [CRC_W-1:0] ONES_NARROW = ONES_WIDE >> (CRC_W - NARROW_W);

    crc_t q, d;
    logic feedback;

    always_comb begin
        d        = q;
        feedback = q.crc[0] ^ data_bit;
        if (init) begin
            d.wide = wide_sel;
            if (preset_zero) begin
                d.crc = '0;
            end else begin
                d.crc = wide_sel ? ONES_WIDE : ONES_NARROW;
            end
        end else if (update) begin
            d.crc = q.crc >> 1;
            if (feedback) begin
                d.crc = d.crc ^ (q.wide ? POLY_WIDE : POLY_NARROW);
            end
        end else if (shift) begin
            d.crc = q.crc >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fcs_bit = ~q.crc[0];
    assign wide    = q.wide;

endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic raw_bit,
    input  logic stuffable,
    output logic stuff_now
);

    localparam int OW = $clog2(RUN_LIMIT + 1);
    localparam logic [OW-1:0] LIMIT = OW'(RUN_LIMIT);

    logic [OW-1:0] ones_q, ones_d;

    assign stuff_now = (ones_q == LIMIT);

    always_comb begin
        ones_d = ones_q;
        if (step) begin
            if (stuff_now) begin
                ones_d = '0;
            end else if (stuffable && raw_bit) begin
                ones_d = ones_q + 1'b1;
            end else begin
                ones_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else begin
            ones_q <= ones_d;
        end
    end

endmodule

// File: rtl/hdlc_tx_rts.sv
module hdlc_tx_rts (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rx_active,
    input  logic       tx_frame,
    output logic       rts_n
);

    logic rts_d, rts_q;

    always_comb begin
        if (mode[1]) begin
            rts_d = mode[0] ? ~rx_active : 1'b1;
        end else begin
            rts_d = ~tx_frame;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_q <= 1'b1;
        end else begin
            rts_q <= rts_d;
        end
    end

    assign rts_n = rts_q;

    AST_RTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> rts_n); // R10

    AST_RTS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (rts_n == !$past(rx_active))); // R11

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    parameter int FCS_NARROW_BITS = 16,
    parameter int FCS_WIDE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              crc32_sel,
    input  logic              crc_preset_zero,
    input  logic              share_flags,
    input  logic [1:0]        rts_mode,
    input  logic              rx_frame_active,
    output logic              tx_bit,
    output logic              tx_bit_valid,
    output logic              rts_n
);

    localparam logic [CNT_W-1:0] BYTE_END   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] NARROW_END = CNT_W'(FCS_NARROW_BITS - 1);
    localparam logic [CNT_W-1:0] WIDE_END   = CNT_W'(FCS_WIDE_BITS - 1);

    seq_t q, d;

    logic stuff_now;
    logic raw_bit;
    logic stuffable;
    logic at_end;
    logic fcs_bit;
    logic fcs_wide;
    logic crc_init;
    logic crc_update;
    logic crc_shift;
    logic take;
    logic in_frame;

    hdlc_tx_crc u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (crc_init),
        .wide_sel    (crc32_sel),
        .preset_zero (crc_preset_zero),
        .update      (crc_update),
        .data_bit    (q.shreg[0]),
        .shift       (crc_shift),
        .fcs_bit     (fcs_bit),
        .wide        (fcs_wide)
    );

    hdlc_tx_stuffer #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (bit_en),
        .raw_bit   (raw_bit),
        .stuffable (stuffable),
        .stuff_now (stuff_now)
    );

    assign in_frame = (q.state == ST_DATA) || (q.state == ST_FCS);

    hdlc_tx_rts u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (rts_mode),
        .rx_active (rx_frame_active),
        .tx_frame  (in_frame),
        .rts_n     (rts_n)
    );

    // Bit source and boundary for the current state
    always_comb begin
        raw_bit   = 1'b0;
        stuffable = 1'b0;
        at_end    = 1'b0;
        case (q.state)
            ST_DATA: begin
                raw_bit   = q.shreg[0];
                stuffable = 1'b1;
                at_end    = (q.cnt == BYTE_END);
            end
            ST_FCS: begin
                raw_bit   = fcs_bit;
                stuffable = 1'b1;
                at_end    = (q.cnt == (fcs_wide ? WIDE_END : NARROW_END));
            end
            default: begin
                raw_bit   = FLAG_OCTET[q.cnt[2:0]];
                stuffable = 1'b0;
                at_end    = (q.cnt == BYTE_END);
            end
        endcase
    end

    // Byte acceptance: only when the last bit of a flag or byte leaves
    always_comb begin
        in_ready = 1'b0;
        if (bit_en && !stuff_now && at_end) begin
            case (q.state)
                ST_IDLE_FLAG:  in_ready = 1'b1;
                ST_CLOSE_FLAG: in_ready = share_flags;
                ST_DATA:       in_ready = ~q.last;
                default:       in_ready = 1'b0;
            endcase
        end
    end

    assign take = in_ready && in_valid;

    // Next-state computation
    always_comb begin
        d          = q;
        d.valid    = bit_en;
        crc_init   = 1'b0;
        crc_update = 1'b0;
        crc_shift  = 1'b0;
        if (bit_en) begin
            if (stuff_now) begin
                d.bit_o = 1'b0;
            end else begin
                d.bit_o = raw_bit;
                d.cnt   = at_end ? '0 : q.cnt + 1'b1;
                if (q.state == ST_DATA) begin
                    crc_update = 1'b1;
                    d.shreg    = q.shreg >> 1;
                end
                if (q.state == ST_FCS) begin
                    crc_shift = 1'b1;
                end
                if (at_end) begin
                    case (q.state)
                        ST_DATA:  d.state = ST_FCS;
                        ST_FCS:   d.state = ST_CLOSE_FLAG;
                        default:  d.state = ST_IDLE_FLAG;
                    endcase
                end
                if (take) begin
                    d.state = ST_DATA;
                    d.shreg = in_data;
                    d.last  = in_last;
                    if (q.state != ST_DATA) begin
                        crc_init = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE_FLAG;
            q.cnt   <= '0;
            q.shreg <= '0;
            q.last  <= 1'b0;
            q.bit_o <= 1'b1;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tx_bit       = q.bit_o;
    assign tx_bit_valid = q.valid;

    AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_now && bit_en) |=> (tx_bit_valid && !tx_bit)); // R3

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (q.state == ST_DATA)); // R2

    AST_RTS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_mode[1] && in_frame) |=> !rts_n); // R9

endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       crc32_sel = 1'b0;
    logic       crc_preset_zero = 1'b0;
    logic       share_flags = 1'b1;
    logic [1:0] rts_mode = 2'b00;
    logic       rx_frame_active = 1'b0;
    logic       tx_bit;
    logic       tx_bit_valid;
    logic       rts_n;

    always #10 clk = ~clk;

    hdlc_tx_framer uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_en          (bit_en),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .in_last         (in_last),
        .in_ready        (in_ready),
        .crc32_sel       (crc32_sel),
        .crc_preset_zero (crc_preset_zero),
        .share_flags     (share_flags),
        .rts_mode        (rts_mode),
        .rx_frame_active (rx_frame_active),
        .tx_bit          (tx_bit),
        .tx_bit_valid    (tx_bit_valid),
        .rts_n           (rts_n)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Stimulus queues and expected frames
    logic [8:0] drv_q[$];
    logic [7:0] scratch[$];
    logic [7:0] exp_bytes[$];
    int         exp_len[$];
    int         exp_gap[$];
    logic [1:0] exp_cfg[$];
    int         committed = 0;

    // Decoder state
    logic [7:0] win = '0;
    int   ones_run = 0;
    int   stuffs = 0;
    bit   synced = 0;
    int   flag_run = 0;
    int   idle_flags = 0;
    int   frames_done = 0;
    logic rx_bits[$];
    logic rx_rts[$];
    logic rx_m0[$];

    // Driver state
    int         div = 1;
    int         div_cnt = 0;
    int         strobe_cnt = 0;
    bit         rx_toggle = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    logic [1:0] last_mode = 2'b00;
    int         mode_age = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fcs_calc(input logic [7:0] dat[$], input logic wide,
                                             input logic pz);
        logic [31:0] c;
        logic fb;
        c = pz ? 32'h0 : (wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
        foreach (dat[i]) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ dat[i][j];
                c = c >> 1;
                if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
            end
        end
        return ~c & (wide ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    endfunction

    task automatic commit(input bit mark_last, input int gap);
        for (int i = 0; i < scratch.size(); i++) begin
            drv_q.push_back({mark_last && (i == scratch.size() - 1), scratch[i]});
            exp_bytes.push_back(scratch[i]);
        end
        exp_len.push_back(scratch.size());
        exp_gap.push_back(gap);
        exp_cfg.push_back({crc32_sel, crc_preset_zero});
        committed++;
        scratch.delete();
    endtask

    task automatic frame_check(input int n);
        int len, gap, fcsn, st_exp, run;
        logic [1:0] cfg;
        logic [7:0] dq[$];
        logic [7:0] got[$];
        logic [7:0] bv;
        logic [31:0] fcs, gfcs;
        logic allbits[$];
        bit ok, rok, all0;
        string tag;
        if (exp_len.size() == 0) begin
            chk(0, "R2", "frame with nothing queued", n, 0);
            return;
        end
        len = exp_len.pop_front();
        gap = exp_gap.pop_front();
        cfg = exp_cfg.pop_front();
        fcsn = cfg[1] ? 4 : 2;
        for (int i = 0; i < len; i++) dq.push_back(exp_bytes.pop_front());
        frames_done++;
        chk(n == (len + fcsn) * 8, "R2", "frame length in bits", n, (len + fcsn) * 8);
        if (n != (len + fcsn) * 8) return;
        for (int k = 0; k < n / 8; k++) begin
            for (int j = 0; j < 8; j++) bv[j] = rx_bits[8 * k + j];
            got.push_back(bv);
        end
        ok = 1;
        for (int i = 0; i < len; i++) if (got[i] != dq[i]) ok = 0;
        chk(ok, "R2", "payload bytes (first)", got[0], dq[0]);
        fcs = fcs_calc(dq, cfg[1], cfg[0]);
        gfcs = 0;
        for (int i = 0; i < fcsn; i++) gfcs = gfcs | (32'(got[len + i]) << (8 * i));
        tag = cfg[0] ? "R6" : (cfg[1] ? "R5" : "R4");
        chk(gfcs == fcs, tag, "frame check sequence", gfcs, fcs);
        foreach (dq[i]) for (int j = 0; j < 8; j++) allbits.push_back(dq[i][j]);
        for (int i = 0; i < fcsn; i++) for (int j = 0; j < 8; j++) allbits.push_back(fcs[8 * i + j]);
        st_exp = 0;
        run = 0;
        foreach (allbits[i]) begin
            if (allbits[i]) begin
                run++;
                if (run == 5) begin
                    st_exp++;
                    run = 0;
                end
            end else begin
                run = 0;
            end
        end
        chk(stuffs == st_exp, "R3", "inserted zeros", stuffs, st_exp);
        if (gap != 0) chk(flag_run == gap, (gap == 1) ? "R7" : "R8", "flags between frames", flag_run, gap);
        rok = 1;
        all0 = 1;
        for (int i = 0; i < n; i++) begin
            if (!rx_m0[i]) all0 = 0;
            else if (rx_rts[i]) rok = 0;
        end
        if (all0) chk(rok, "R9", "rts_n low during frame bits", !rok, 0);
    endtask

    task automatic handle_flag();
        int n;
        bit allm, high;
        n = rx_bits.size() - 8;
        if (synced && n >= 0) begin
            allm = 1;
            high = 1;
            for (int i = n; i < n + 8; i++) begin
                if (!rx_m0[i]) allm = 0;
                else if (!rx_rts[i]) high = 0;
            end
            if (allm) chk(high, "R9", "rts_n high during flag bits", high, 1);
        end
        if (!synced) begin
            synced = 1;
            flag_run = 1;
        end else if (n == 0) begin
            flag_run++;
            idle_flags++;
        end else begin
            frame_check(n);
            flag_run = 1;
        end
        rx_bits.delete();
        rx_rts.delete();
        rx_m0.delete();
        stuffs = 0;
    endtask

    task automatic decode_bit(input logic b);
        win = {b, win[7:1]};
        if (b) begin
            ones_run++;
            if (ones_run == 7) chk(0, "R3", "seven ones in a row", 7, 6);
            rx_bits.push_back(b);
            rx_rts.push_back(rts_n);
            rx_m0.push_back(!rts_mode[1]);
        end else begin
            if (ones_run == 5) begin
                stuffs++;
            end else begin
                rx_bits.push_back(b);
                rx_rts.push_back(rts_n);
                rx_m0.push_back(!rts_mode[1]);
            end
            ones_run = 0;
        end
        if (win == 8'h7E) handle_flag();
    endtask

    task automatic monitor();
        if (rts_mode != last_mode) begin
            mode_age = 0;
            last_mode = rts_mode;
        end else if (mode_age < 10) begin
            mode_age++;
        end
        chk(tx_bit_valid == bit_en, "R1", "tx_bit_valid follows strobe", tx_bit_valid, bit_en);
        if (mode_age >= 2 && rts_mode == 2'b10) chk(rts_n == 1'b1, "R10", "rts_n idle high", rts_n, 1);
        if (mode_age >= 2 && rts_mode == 2'b11)
            chk(rts_n == !rx_frame_active, "R11", "rts_n follows receiver", rts_n, !rx_frame_active);
        if (tx_bit_valid) decode_bit(tx_bit);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) monitor();
            bit_en = (div_cnt == 0);
            div_cnt = (div_cnt + 1 >= div) ? 0 : div_cnt + 1;
            in_valid = (drv_q.size() > 0);
            if (drv_q.size() > 0) begin
                in_data = drv_q[0][7:0];
                in_last = drv_q[0][8];
            end else begin
                in_data = '0;
                in_last = 1'b0;
            end
            if (rx_toggle) begin
                lfsr = lfsr * 32'd1103515245 + 32'd12345;
                rx_frame_active = lfsr[16];
            end
            #1;
            if (rst_n && bit_en) strobe_cnt++;
            if (rst_n && in_valid && in_ready) begin
                chk(bit_en == 1'b1, "R2", "ready only with strobe", bit_en, 1);
                chk(strobe_cnt >= 8, "R2", "strobes between accepted bytes", strobe_cnt, 8);
                strobe_cnt = 0;
                drv_q.pop_front();
            end
        end
    end

    task automatic wait_done();
        while (exp_len.size() != 0 || drv_q.size() != 0) @(negedge clk);
        repeat (40 * div) @(negedge clk);
    endtask

    task automatic set_cfg(input logic sel, input logic pz, input logic sh,
                           input logic [1:0] md, input int dv);
        @(negedge clk);
        #2;
        crc32_sel = sel;
        crc_preset_zero = pz;
        share_flags = sh;
        rts_mode = md;
        div = dv;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #2;
        chk(rts_n == 1'b1, "R1", "rts_n in reset", rts_n, 1);
        chk(tx_bit_valid == 1'b0, "R1", "tx_bit_valid in reset", tx_bit_valid, 0);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        chk(idle_flags >= 3, "R1", "idle flags seen", idle_flags, 3);
        chk(frames_done == 0, "R1", "no frame while idle", frames_done, 0);

        // 16-bit CRC, preset ones, runs of ones
        scratch = '{8'h01, 8'h7E, 8'hFF, 8'hFF, 8'h3C};
        commit(1, 0);
        wait_done();

        // 32-bit CRC at a slower strobe, plus a one-byte frame
        set_cfg(1, 0, 1, 2'b00, 3);
        scratch = '{8'h11, 8'h22, 8'hFF, 8'hF8, 8'hA5, 8'h00};
        commit(1, 0);
        wait_done();
        scratch = '{8'hE7};
        commit(1, 0);
        wait_done();

        // Zero preset for both widths
        set_cfg(0, 1, 1, 2'b00, 2);
        scratch = '{8'h80, 8'h7C, 8'h3F};
        commit(1, 0);
        wait_done();
        set_cfg(1, 1, 1, 2'b01, 2);
        scratch = '{8'hFF, 8'h00, 8'hFF};
        commit(1, 0);
        wait_done();

        // Shared flags, back to back
        set_cfg(0, 0, 1, 2'b00, 1);
        scratch = '{8'hC3, 8'h5A, 8'h1F};
        commit(1, 0);
        scratch = '{8'hF0, 8'h0F};
        commit(1, 1);
        wait_done();

        // Separate flags, back to back
        set_cfg(0, 0, 0, 2'b00, 1);
        scratch = '{8'h12, 8'h34};
        commit(1, 0);
        scratch = '{8'h56, 8'h78, 8'h9A};
        commit(1, 2);
        wait_done();

        // R12: source runs dry before a last byte is marked
        set_cfg(0, 0, 1, 2'b00, 2);
        scratch = '{8'h55, 8'hAA};
        commit(0, 0);
        wait_done();

        // RTS held high, then following the receiver
        set_cfg(1, 0, 1, 2'b10, 2);
        scratch = '{8'h66, 8'h99, 8'hFF};
        commit(1, 0);
        wait_done();
        set_cfg(0, 0, 1, 2'b11, 1);
        rx_toggle = 1;
        scratch = '{8'h0E, 8'hFE};
        commit(1, 0);
        wait_done();
        rx_toggle = 0;

        chk(frames_done == committed, "R2", "frames decoded", frames_done, committed);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual unfinished expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule